// File: doc/BRIEF.md
# Guarded Page Table Walker

This block turns a virtual address into a physical address by walking a tree of tables held in memory. Each level of the tree has 16 entries and is indexed by the next four bits of the virtual page number, starting at its most significant end. An entry carries a guard of 0 to 8 bits. The guard must equal the address bits that follow the index, and when it does, those bits are skipped. A single entry can therefore stand in for whole levels of a sparse address space. An entry is either a leaf, which supplies a physical frame number, or a link, which supplies the base of the next table.

A client presents one virtual address at a time together with the base of the root table. The walker issues one table read per level through a port that allows a single outstanding read. It ends with a one-cycle done pulse that carries either the physical address or a fault flag and a fault code. The default layout uses a 24-bit virtual address, a 12-bit page offset and a 12-bit frame or table pointer.

Top module: `gpt_walker`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and mem_rd_en is 0.
- R2: A request is accepted in a cycle where req_valid and req_ready are both 1. From the next cycle, req_ready stays 0 until the cycle in which done is 1.
- R3: Each table read puts mem_rd_addr = {table base, next 4 unconsumed page-number bits}, with the most significant bits consumed first. The base of the first read is the root_base value sampled at acceptance. Exactly one read is issued per level, mem_rd_en is a one-cycle strobe, and no new read starts before mem_rd_valid returns.
- R4: The table entry layout is bit 25 valid, bit 24 leaf, bits 23:20 guard length, bits 19:12 guard value and bits 11:0 pointer or frame. An entry with valid 0, or with a guard length above 8, ends the walk with fault code 1.
- R5: The low n bits of the guard value (n = guard length) are compared with the n page-number bits that follow the index. Guard bit n-1 is compared with the first of those bits, and guard bits above n are ignored. A mismatch, or an n larger than the bits that remain, gives fault code 2.
- R6: On a match, the n guard bits are consumed. A guard length of 0 consumes nothing and always matches.
- R7: A leaf entry that leaves no page-number bits unconsumed completes the walk with fault 0, code 0 and pa = {frame, the 12 offset bits of the request}.
- R8: A leaf entry that leaves page-number bits unconsumed gives fault code 3.
- R9: A link entry that leaves fewer than 4 page-number bits gives fault code 4. Otherwise the next read uses the entry's pointer as the table base.
- R10: done is a one-cycle pulse. fault is 1 exactly when the code is nonzero, and pa is 0 on a fault.
- R11: done rises in the cycle after the cycle in which the final mem_rd_valid was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 12 | Root table pointer, sampled on acceptance |
| req_valid | input | 1 | Translation request present |
| req_va | input | 24 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 16 | Table entry address {base, index} |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 26 | Table entry |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | 0 none, 1 invalid, 2 guard, 3 bits left at leaf, 4 bits short at link |
| pa | output | 24 | Physical address |

## Verification
A request accepted at a clock edge makes mem_rd_en high for the cycle that follows. After each returned entry, the next strobe or the done pulse comes exactly one cycle later. The bench drives and samples on the falling edge and models a memory with a random latency of 1 to 3 cycles. It records the cycle in which it presents each response and requires done in the very next cycle, with done gone again one cycle after that. While a walk is in progress, the bench watches req_ready at every falling edge and changes root_base, so that a base sampled late would show up as wrong read addresses.

// File: rtl/gpt_pkg.sv
// Package: shared sizes, entry type and fault codes of the guarded walker.
// Assumes the default geometry; every other width derives from these.
package gpt_pkg;
    parameter int VA_W   = 24;
    parameter int OFF_W  = 12;
    parameter int IDX_W  = 4;
    parameter int GLEN_W = 4;
    parameter int GMAX   = 8;
    parameter int PTR_W  = 12;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int ENT_W = 2 + GLEN_W + GMAX + PTR_W;
    localparam int MA_W  = PTR_W + IDX_W;
    localparam int PA_W  = PTR_W + OFF_W;
    localparam int CNT_W = $clog2(VPN_W + 1);

    typedef struct packed {
        logic              valid;
        logic              is_leaf;
        logic [GLEN_W-1:0] glen;
        logic [GMAX-1:0]   guard;
        logic [PTR_W-1:0]  ptr;
    } ent_t;

    typedef enum logic [2:0] {
        F_NONE     = 3'd0,
        F_INVALID  = 3'd1,
        F_GUARD    = 3'd2,
        F_LEFTOVER = 3'd3,
        F_SHORT    = 3'd4
    } fault_e;
endpackage

// File: rtl/gpt_entry_decode.sv
// Module: unpacks a fetched table entry and sizes its guard against the
// page-number bits still unconsumed. Purely combinational.
// Assumes rem never exceeds VPN_W.
module gpt_entry_decode
    import gpt_pkg::*;
(
    input  logic [ENT_W-1:0] raw,
    input  logic [CNT_W-1:0] rem,
    output ent_t             ent,
    output logic             glen_ok,
    output logic             fits,
    output logic [CNT_W-1:0] left
);
    localparam int CW = (CNT_W > GLEN_W) ? CNT_W : GLEN_W;

    logic [CW-1:0] glen_w;
    logic [CW-1:0] rem_w;

    // Split the raw word and compare lengths in a common width.
    always_comb begin
        ent     = ent_t'(raw);
        glen_w  = CW'(ent.glen);
        rem_w   = CW'(rem);
        glen_ok = (glen_w <= CW'(GMAX));
        fits    = (glen_w <= rem_w);
        left    = CNT_W'(rem_w - glen_w);
    end
endmodule

// File: rtl/gpt_guard_match.sv
// Module: compares the low glen bits of a guard with the leading glen bits
// of the page-number window, with the guard's MSB-of-length against the
// first window bit. Assumes glen <= GMAX has been checked elsewhere.
module gpt_guard_match
    import gpt_pkg::*;
(
    input  logic [GMAX-1:0]   guard,
    input  logic [GLEN_W-1:0] glen,
    input  logic [GMAX-1:0]   window,
    output logic              match
);
    logic [GMAX-1:0]   aligned;
    logic [GLEN_W-1:0] sh;

    // Left-justify the guard, then compare only the first glen positions.
    always_comb begin
        sh      = GLEN_W'(GMAX) - glen;
        aligned = guard << sh;
        match   = 1'b1;
        for (int i = 0; i < GMAX; i++) begin
            if (GLEN_W'(i) < glen && aligned[GMAX-1-i] != window[GMAX-1-i])
                match = 1'b0;
        end
    end
endmodule

// File: rtl/gpt_vpn_cursor.sv
// Module: holds the unconsumed page-number bits, left-justified, and their
// count. Consumes an index or a guard on command.
// Assumes callers never consume more bits than remain.
module gpt_vpn_cursor
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [VPN_W-1:0]  vpn_in,
    input  logic              take_idx,
    input  logic              take_glen,
    input  logic [GLEN_W-1:0] glen,
    output logic [VPN_W-1:0]  vsh,
    output logic [CNT_W-1:0]  rem,
    output logic [IDX_W-1:0]  idx
);
    // Shift register and counter for the consumption point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsh <= '0;
            rem <= '0;
        end else if (load) begin
            vsh <= vpn_in;
            rem <= CNT_W'(VPN_W);
        end else if (take_idx) begin
            vsh <= vsh << IDX_W;
            rem <= rem - CNT_W'(IDX_W);
        end else if (take_glen) begin
            vsh <= vsh << glen;
            rem <= rem - CNT_W'(glen);
        end
    end

    // The next index is always the leading bits.
    assign idx = vsh[VPN_W-1 -: IDX_W];

    p_idx_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_idx |-> (rem >= CNT_W'(IDX_W)))
        else $error("index taken with too few bits left");
endmodule

// File: rtl/gpt_walker.sv
// Module: top of the guarded page table walker. Accepts one virtual
// address, reads one entry per level, matches guards and ends with a
// done pulse carrying a physical address or a fault code.
// Assumes the memory answers each strobe with exactly one mem_rd_valid.
module gpt_walker
    import gpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] root_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             req_ready,
    output logic             mem_rd_en,
    output logic [MA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [ENT_W-1:0] mem_rd_data,
    output logic             done,
    output logic             fault,
    output logic [2:0]       fault_code,
    output logic [PA_W-1:0]  pa
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

    state_e           state;
    logic [PTR_W-1:0] base;
    logic [OFF_W-1:0] off;
    logic [VPN_W-1:0] vsh;
    logic [CNT_W-1:0] rem;
    logic [IDX_W-1:0] idx;
    ent_t             ent;
    logic             glen_ok, fits, match;
    logic [CNT_W-1:0] left;
    fault_e           code_n;
    logic             leaf_ok, descend, accept, resp, finish;

    assign req_ready   = (state == S_IDLE);
    assign accept      = req_valid && req_ready;
    assign resp        = (state == S_WAIT) && mem_rd_valid;
    assign finish      = resp && !descend;
    assign mem_rd_en   = (state == S_ISSUE);
    assign mem_rd_addr = {base, idx};

    gpt_vpn_cursor u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .vpn_in    (req_va[VA_W-1:OFF_W]),
        .take_idx  (state == S_ISSUE),
        .take_glen (resp && descend),
        .glen      (ent.glen),
        .vsh       (vsh),
        .rem       (rem),
        .idx       (idx)
    );

    gpt_entry_decode u_dec (
        .raw     (mem_rd_data),
        .rem     (rem),
        .ent     (ent),
        .glen_ok (glen_ok),
        .fits    (fits),
        .left    (left)
    );

    gpt_guard_match u_guard (
        .guard  (ent.guard),
        .glen   (ent.glen),
        .window (vsh[VPN_W-1 -: GMAX]),
        .match  (match)
    );

    // Classify the returned entry in priority order.
    always_comb begin
        code_n  = F_NONE;
        leaf_ok = 1'b0;
        descend = 1'b0;
        if (!ent.valid || !glen_ok)
            code_n = F_INVALID;
        else if (!fits || !match)
            code_n = F_GUARD;
        else if (ent.is_leaf) begin
            if (left != '0) code_n = F_LEFTOVER;
            else            leaf_ok = 1'b1;
        end else if (left < CNT_W'(IDX_W))
            code_n = F_SHORT;
        else
            descend = 1'b1;
    end

    // Walk sequencing: idle, strobe a read, wait for its data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else begin
            unique case (state)
                S_IDLE:  if (accept) state <= S_ISSUE;
                S_ISSUE: state <= S_WAIT;
                S_WAIT:  if (resp) state <= descend ? S_ISSUE : S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Table base and page offset for the walk in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            off  <= '0;
        end else if (accept) begin
            base <= root_base;
            off  <= req_va[OFF_W-1:0];
        end else if (resp && descend)
            base <= ent.ptr;
    end

    // Result registers, updated every cycle and meaningful with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_code <= F_NONE;
            pa         <= '0;
        end else begin
            done       <= finish;
            fault      <= finish && !leaf_ok;
            fault_code <= finish ? code_n : F_NONE;
            pa         <= (finish && leaf_ok) ? {ent.ptr, off} : '0;
        end
    end

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready high after acceptance");

    p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en)
        else $error("read strobe longer than one cycle");

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    p_pa_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (pa == '0 && fault_code != 3'd0))
        else $error("fault result inconsistent");

    p_done_after_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd_valid))
        else $error("done without preceding read data");
endmodule

// File: tb/tb_gpt_walker.sv
`timescale 1ns/1ps
module tb_gpt_walker;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] root_base = 0;
    logic        req_valid = 0;
    logic [23:0] req_va = 0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 0;
    logic [25:0] mem_rd_data = 0;
    logic        done, fault;
    logic [2:0]  fault_code;
    logic [23:0] pa;

    gpt_walker dut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .fault(fault), .fault_code(fault_code), .pa(pa)
    );

    always #4 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0, finished = 0;
    logic [25:0] tmem [int];
    int got_addr [$];
    int wr_addr [$];
    int lat_cnt = 0, last_resp_cyc = -10;
    logic [25:0] rd_word;

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: random latency 1..3, one read in flight.
    always @(negedge clk) begin
        mem_rd_valid = 0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                mem_rd_valid = 1;
                mem_rd_data = rd_word;
                last_resp_cyc = cyc;
            end
        end else if (rst_n && mem_rd_en) begin
            got_addr.push_back(int'(mem_rd_addr));
            rd_word = tmem.exists(int'(mem_rd_addr)) ? tmem[int'(mem_rd_addr)] : 26'd0;
            lat_cnt = 1 + int'($urandom % 3);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [25:0] mk(input int v, input int lf, input int gl, input int gd, input int p);
        return {v[0], lf[0], gl[3:0], gd[7:0], p[11:0]};
    endfunction

    // Reference walk computed arithmetically from the requirements.
    task automatic model(input int va, input int root, output int epa, output int ecode, output int eaddr[$]);
        int vsh = (va >> 12) & 'hFFF;
        int rem = 12;
        int base = root;
        eaddr.delete();
        epa = 0;
        forever begin
            int addr = (base << 4) | ((vsh >> 8) & 15);
            logic [25:0] e;
            int gl, gd, mask;
            eaddr.push_back(addr);
            vsh = (vsh << 4) & 'hFFF;
            rem -= 4;
            e = tmem.exists(addr) ? tmem[addr] : 26'd0;
            gl = int'(e[23:20]);
            gd = int'(e[19:12]);
            if (!e[25] || gl > 8) begin ecode = 1; return; end
            if (gl > rem) begin ecode = 2; return; end
            mask = (1 << gl) - 1;
            if ((vsh >> (12 - gl)) != (gd & mask)) begin ecode = 2; return; end
            if (e[24]) begin
                if (rem - gl != 0) begin ecode = 3; return; end
                ecode = 0;
                epa = (int'(e[11:0]) << 12) | (va & 'hFFF);
                return;
            end
            if (rem - gl < 4) begin ecode = 4; return; end
            vsh = (vsh << gl) & 'hFFF;
            rem -= gl;
            base = int'(e[11:0]);
        end
    endtask

    // Build a translating path for va below root with random guard lengths.
    task automatic build(input int va, input int root);
        int vsh = (va >> 12) & 'hFFF;
        int rem = 12, base = root, next_tbl = 'h100;
        forever begin
            int addr = (base << 4) | ((vsh >> 8) & 15);
            int gl, gd, noise;
            vsh = (vsh << 4) & 'hFFF;
            rem -= 4;
            if (rem < 4 || ($urandom % 2) == 0) begin
                gl = rem;
                noise = int'($urandom) & ~((1 << gl) - 1) & 'hFF;
                gd = (vsh >> (12 - gl)) | noise;
                tmem[addr] = mk(1, 1, gl, gd, int'($urandom) & 'hFFF);
                wr_addr.push_back(addr);
                return;
            end
            gl = int'($urandom % (rem - 3));
            noise = int'($urandom) & ~((1 << gl) - 1) & 'hFF;
            gd = (vsh >> (12 - gl)) | noise;
            tmem[addr] = mk(1, 0, gl, gd, next_tbl);
            wr_addr.push_back(addr);
            vsh = (vsh << gl) & 'hFFF;
            rem -= gl;
            base = next_tbl;
            next_tbl++;
        end
    endtask

    // One walk: drive, wait, compare with the model; dcode < 0 means random.
    task automatic run_walk(input int va, input int root, input int dcode, input string tag);
        int epa, ecode, n;
        int eaddr[$];
        bit ready_bad = 0;
        model(va, root, epa, ecode, eaddr);
        if (dcode >= 0) check(ecode == dcode, {tag, " table setup"}, ecode, dcode);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        got_addr.delete();
        req_va = va[23:0];
        root_base = root[11:0];
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        root_base = 12'($urandom);
        req_va = 24'($urandom);
        n = 0;
        while (!done && n < 400) begin
            if (req_ready) ready_bad = 1;
            @(negedge clk);
            n++;
        end
        check(done, "R10 done seen", int'(done), 1);
        check(!ready_bad, "R2 ready low during walk", int'(ready_bad), 0);
        check(req_ready, "R2 ready back with done", int'(req_ready), 1);
        check(int'(fault_code) == ecode, {tag, " fault code"}, int'(fault_code), ecode);
        check(fault == (ecode != 0), "R10 fault flag", int'(fault), int'(ecode != 0));
        check(int'(pa) == epa, "R7 pa", int'(pa), epa);
        check(got_addr.size() == eaddr.size(), "R3 read count", got_addr.size(), eaddr.size());
        for (int i = 0; i < eaddr.size() && i < got_addr.size(); i++)
            check(got_addr[i] == eaddr[i], "R3 read address", got_addr[i], eaddr[i]);
        check(cyc == last_resp_cyc + 1, "R11 done timing", cyc, last_resp_cyc + 1);
        @(negedge clk);
        check(!done, "R10 done one cycle", int'(done), 0);
    endtask

    initial begin
        #(8.0 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s;
        s = int'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !done && !mem_rd_en, "R1 reset state",
              {req_ready, done, mem_rd_en}, 3'b100);

        // R6: linear tree, guard length 0 at every level.
        tmem.delete();
        tmem[('h010 << 4) | 'hA] = mk(1, 0, 0, 'hFF, 'h020);
        tmem[('h020 << 4) | 'hB] = mk(1, 0, 0, 'h00, 'h030);
        tmem[('h030 << 4) | 'hC] = mk(1, 1, 0, 'h5A, 'h777);
        run_walk('hABC345, 'h010, 0, "R6 zero guards");

        // R5, R7: single level, 8-bit guard skips two levels.
        tmem.delete();
        tmem[('h005 << 4) | 'hA] = mk(1, 1, 8, 'hBC, 'h9E1);
        run_walk('hABC123, 'h005, 0, "R7 single level");

        // R4: empty slot and oversize guard length.
        tmem.delete();
        run_walk('hABC123, 'h005, 1, "R4 invalid entry");
        tmem[('h005 << 4) | 'hA] = mk(1, 1, 9, 'hBC, 'h9E1);
        run_walk('hABC123, 'h005, 1, "R4 guard length 9");

        // R5: wrong guard bit, and guard longer than the bits left.
        tmem[('h005 << 4) | 'hA] = mk(1, 1, 8, 'hBD, 'h9E1);
        run_walk('hABC123, 'h005, 2, "R5 guard mismatch");
        tmem[('h005 << 4) | 'hA] = mk(1, 0, 0, 0, 'h007);
        tmem[('h007 << 4) | 'hB] = mk(1, 1, 6, 'h0C, 'h123);
        run_walk('hABC123, 'h005, 2, "R5 guard too long");

        // R8: leaf with four bits still unconsumed.
        tmem.delete();
        tmem[('h005 << 4) | 'hA] = mk(1, 1, 4, 'hFB, 'h321);
        run_walk('hABC123, 'h005, 3, "R8 leftover bits");

        // R9: link leaving only two bits.
        tmem[('h005 << 4) | 'hA] = mk(1, 0, 6, 'h2F, 'h044);
        run_walk('hABC123, 'h005, 4, "R9 short link");

        // Random trees, some entries corrupted afterwards.
        for (int t = 0; t < 300; t++) begin
            int va = int'($urandom) & 'hFFFFFF;
            int root = int'($urandom) & 'hFF;
            tmem.delete();
            wr_addr.delete();
            build(va, root);
            if (($urandom % 4) == 0) begin
                int k = int'($urandom % wr_addr.size());
                tmem[wr_addr[k]] = tmem[wr_addr[k]] ^ 26'(1 << ($urandom % 26));
            end
            run_walk(va, root, -1, "R5 R9 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule